// File: doc/BRIEF.md
# Pre-Adder Multiplier Operand Datapath

This block is the input side of a signed multiply unit. It takes a 30-bit A word, a 25-bit D word and an 18-bit B word. Each input passes through its own short register chain, and each chain stage has its own clock enable. A 25-bit pre-adder then builds the multiplier's first operand from D and the low 25 bits of A. The first operand can be A alone, D alone, the sum D+A or the difference D−A. A 2-bit operand-select input picks which one, and it may change on every cycle.

The multiplier is signed, 25 by 18 bits. A second per-cycle select chooses what goes to the registered 48-bit result. In multiply mode the result is the 43-bit product, sign-extended to 48 bits. In concatenate mode the result is the raw A:B bus, with A in bits 47:18 and B in bits 17:0.

Both selects travel through the same register stages as the data, so switching between modes never misaligns the pipeline. Parameters set the depths: A has 0–2 stages, B has 0–2 stages and D has 0–1 stages. B and D are padded up to the A depth with stages that follow the A enables.

Top module: `opd_preadd_dp`

## Requirements
- R1: While `rst_n` is low, every register is cleared and `result_o` reads 0.
- R2: With all enables high, a set of inputs shows up on `result_o` after AREG+1 rising edges (3 with the default AREG=2).
- R3: When `mode_i`=00, the first operand is `a_i[24:0]` taken as signed. `a_i[29:25]` has no effect on the product.
- R4: When `mode_i`=01, the first operand is `d_i + a_i[24:0]`, wrapped to 25 bits.
- R5: When `mode_i`=10, the first operand is `d_i - a_i[24:0]`, wrapped to 25 bits.
- R6: When `mode_i`=11, the first operand is `d_i`, and A has no effect on the product.
- R7: When `mul_i`=1, `result_o` is the signed product of the first operand and `b_i`, sign-extended from 43 to 48 bits.
- R8: When `mul_i`=0, `result_o` = {`a_i`, `b_i`}, and both `d_i` and `mode_i` have no effect.
- R9: `mode_i` and `mul_i` may change on every cycle. Each result uses the selects that were presented together with its own data.
- R10: A register stage with its enable low keeps its value. While all enables stay low, `result_o` holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 30 | A word: operand source (low 25 bits) and upper part of the concatenation |
| b_i | input | 18 | B word: second multiplier operand and low part of the concatenation |
| d_i | input | 25 | D word for the pre-adder |
| mode_i | input | 2 | First-operand select: 00 A, 01 D+A, 10 D−A, 11 D |
| mul_i | input | 1 | 1 = product result, 0 = A:B concatenation result |
| ce_a_i | input | 2 | Per-stage enables of the A chain (also used by the select chain and by pad stages) |
| ce_b_i | input | 2 | Per-stage enables of the B chain |
| ce_d_i | input | 1 | Enable of the D register stage |
| result_o | output | 48 | Registered product or concatenation |

## Verification
Each operand-select code is driven with values that expose the wrong choice. In mode 00, A carries nonzero upper bits, so a wrong slice changes the product. In mode 11, A carries garbage, so any leak of A shows up. The sum and difference are each tried once with small values and once with values that cross the 25-bit boundary, which separates a wrapped result from a widened one. Products cover negative-by-negative, negative-by-positive and the extreme values. Concatenate-mode vectors change D and the select in between, to show that those inputs are ignored. A randomized stream that flips both selects on every cycle tells balanced control timing apart from controls that arrive a stage early or late. A phase with all enables low shows whether the result is frozen.

// File: rtl/opd_pkg.sv
package opd_pkg;
  localparam int A_W    = 30;
  localparam int B_W    = 18;
  localparam int OPD_W  = 25;
  localparam int PROD_W = OPD_W + B_W;
  localparam int RES_W  = A_W + B_W;

  typedef enum logic [1:0] {
    OPSEL_A   = 2'b00,
    OPSEL_DPA = 2'b01,
    OPSEL_DMA = 2'b10,
    OPSEL_D   = 2'b11
  } opsel_e;
endpackage

// File: rtl/opd_dly_chain.sv
module opd_dly_chain #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   ce,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_reg
      for (genvar k = 0; k < DEPTH; k++) begin : g_stg
        logic [W-1:0] src;
        logic [W-1:0] stg_n;
        logic [W-1:0] stg_q;
        if (k == 0) begin : g_first
          assign src = din;
        end else begin : g_next
          assign src = g_stg[k-1].stg_q;
        end
        always_comb begin
          stg_n = ce[k] ? src : stg_q;
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q <= '0;
          else        stg_q <= stg_n;
        end
      end
      assign dout = g_stg[DEPTH-1].stg_q;
    end
  endgenerate
endmodule

// File: rtl/opd_preadd.sv
module opd_preadd
  import opd_pkg::*;
(
  input  logic [OPD_W-1:0] a_lo_i,
  input  logic [OPD_W-1:0] d_i,
  input  logic [1:0]       mode_i,
  output logic [OPD_W-1:0] opd_o
);
  logic [OPD_W-1:0] sum_w;
  logic [OPD_W-1:0] diff_w;

  assign sum_w  = d_i + a_lo_i;
  assign diff_w = d_i - a_lo_i;

  always_comb begin
    case (opsel_e'(mode_i))
      OPSEL_A:   opd_o = a_lo_i;
      OPSEL_DPA: opd_o = sum_w;
      OPSEL_DMA: opd_o = diff_w;
      default:   opd_o = d_i;
    endcase
  end
endmodule

// File: rtl/opd_mul_out.sv
module opd_mul_out
  import opd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPD_W-1:0]  opd_i,
  input  logic [A_W-1:0]    a_i,
  input  logic [B_W-1:0]    b_i,
  input  logic              mul_i,
  output logic [RES_W-1:0]  result_o
);
  logic signed [PROD_W-1:0] prod_w;
  logic [RES_W-1:0]         res_n;

  assign prod_w = $signed({{B_W{opd_i[OPD_W-1]}}, opd_i}) *
                  $signed({{OPD_W{b_i[B_W-1]}}, b_i});

  always_comb begin
    if (mul_i) res_n = {{(RES_W-PROD_W){prod_w[PROD_W-1]}}, prod_w};
    else       res_n = {a_i, b_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_o <= '0;
    else        result_o <= res_n;
  end

  a_r1_reset: assert property (@(posedge clk) !rst_n |-> result_o == '0);

  a_r8_concat: assert property (@(posedge clk) disable iff (!rst_n)
    !mul_i |=> result_o == {$past(a_i), $past(b_i)});

  a_r7_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    mul_i |=> (result_o[RES_W-1:PROD_W-1] == '0 || result_o[RES_W-1:PROD_W-1] == '1));
endmodule

// File: rtl/opd_preadd_dp.sv
module opd_preadd_dp
  import opd_pkg::*;
#(
  parameter int AREG = 2,
  parameter int BREG = 2,
  parameter int DREG = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  input  logic [OPD_W-1:0] d_i,
  input  logic [1:0]       mode_i,
  input  logic             mul_i,
  input  logic [1:0]       ce_a_i,
  input  logic [1:0]       ce_b_i,
  input  logic             ce_d_i,
  output logic [RES_W-1:0] result_o
);
  localparam int CTL_W = 3;

  logic [1:0]       ce_bv;
  logic [1:0]       ce_dv;
  logic [A_W-1:0]   a_q;
  logic [B_W-1:0]   b_q;
  logic [OPD_W-1:0] d_q;
  logic [CTL_W-1:0] ctl_q;
  logic [OPD_W-1:0] opd_w;
  logic             all_off;

  for (genvar k = 0; k < 2; k++) begin : g_ce
    if (k < BREG) begin : g_b_own
      assign ce_bv[k] = ce_b_i[k];
    end else begin : g_b_pad
      assign ce_bv[k] = ce_a_i[k];
    end
    if (k < DREG) begin : g_d_own
      assign ce_dv[k] = ce_d_i;
    end else begin : g_d_pad
      assign ce_dv[k] = ce_a_i[k];
    end
  end

  opd_dly_chain #(.W(A_W), .DEPTH(AREG)) u_a_chain (
    .clk(clk), .rst_n(rst_n), .ce(ce_a_i), .din(a_i), .dout(a_q));

  opd_dly_chain #(.W(B_W), .DEPTH(AREG)) u_b_chain (
    .clk(clk), .rst_n(rst_n), .ce(ce_bv), .din(b_i), .dout(b_q));

  opd_dly_chain #(.W(OPD_W), .DEPTH(AREG)) u_d_chain (
    .clk(clk), .rst_n(rst_n), .ce(ce_dv), .din(d_i), .dout(d_q));

  opd_dly_chain #(.W(CTL_W), .DEPTH(AREG)) u_ctl_chain (
    .clk(clk), .rst_n(rst_n), .ce(ce_a_i), .din({mul_i, mode_i}), .dout(ctl_q));

  opd_preadd u_preadd (
    .a_lo_i(a_q[OPD_W-1:0]), .d_i(d_q), .mode_i(ctl_q[1:0]), .opd_o(opd_w));

  opd_mul_out u_mul_out (
    .clk(clk), .rst_n(rst_n), .opd_i(opd_w), .a_i(a_q), .b_i(b_q),
    .mul_i(ctl_q[2]), .result_o(result_o));

  assign all_off = (ce_a_i == 2'b00) && (ce_b_i == 2'b00) && !ce_d_i;

  // R10: two cycles with every enable low leave the result frozen
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (all_off && $past(all_off)) |=> $stable(result_o));
endmodule

// File: tb/opd_preadd_dp_tb.sv
`timescale 1ns/1ps
module opd_preadd_dp_tb;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [29:0] a_i;
  logic [17:0] b_i;
  logic [24:0] d_i;
  logic [1:0]  mode_i;
  logic        mul_i;
  logic [1:0]  ce_a_i, ce_b_i;
  logic        ce_d_i;
  logic [47:0] result_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [47:0] exp_q[$];
  int          due_q[$];
  string       req_q[$];

  always #4 clk = ~clk;

  opd_preadd_dp u_dut (
    .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .d_i(d_i),
    .mode_i(mode_i), .mul_i(mul_i), .ce_a_i(ce_a_i), .ce_b_i(ce_b_i),
    .ce_d_i(ce_d_i), .result_o(result_o));

  function automatic logic [47:0] model(logic [29:0] a, logic [17:0] b,
                                        logic [24:0] d, logic [1:0] m, logic mu);
    logic [24:0] op;
    logic [47:0] p;
    case (m)
      2'b00: op = a[24:0];
      2'b01: op = d + a[24:0];
      2'b10: op = d - a[24:0];
      default: op = d;
    endcase
    p = {{23{op[24]}}, op} * {{30{b[17]}}, b};
    return mu ? p : {a, b};
  endfunction

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [29:0] a, logic [17:0] b, logic [24:0] d,
                       logic [1:0] m, logic mu, string req);
    @(negedge clk);
    a_i = a; b_i = b; d_i = d; mode_i = m; mul_i = mu;
    exp_q.push_back(model(a, b, d, m, mu));
    due_q.push_back(cyc + LAT);
    req_q.push_back(req);
  endtask

  task automatic flush();
    repeat (LAT + 1) @(posedge clk);
    #3;
  endtask

  // monitor: scoreboard compare, R2 latency is implied by the due cycle
  always @(posedge clk) begin
    cyc++;
    #2;
    while (due_q.size() > 0 && due_q[0] == cyc) begin
      check(req_q[0], result_o, exp_q[0]);
      void'(exp_q.pop_front());
      void'(due_q.pop_front());
      void'(req_q.pop_front());
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a_i = '0; b_i = '0; d_i = '0; mode_i = 2'b00; mul_i = 1'b1;
    ce_a_i = 2'b11; ce_b_i = 2'b11; ce_d_i = 1'b1;
    repeat (3) @(posedge clk);
    #2 check("R1", result_o, 48'h0);
    @(negedge clk) rst_n = 1'b1;

    // R2 latency after idle
    drive(30'h0000_0003, 18'h00005, 25'h0, 2'b00, 1'b1, "R2");
    // R3 upper A bits must not reach the product
    drive(30'h3E00_0007, 18'h00003, 25'h1, 2'b00, 1'b1, "R3");
    drive(30'h2100_0000 | 30'h1FF_FFFF, 18'h00002, 25'h5, 2'b00, 1'b1, "R3");
    // R4 sum, normal and wrap past +2^24-1
    drive(30'h0000_0010, 18'h00003, 25'h20, 2'b01, 1'b1, "R4");
    drive(30'h0000_0001, 18'h00001, 25'h0FF_FFFF, 2'b01, 1'b1, "R4");
    // R5 difference, normal and wrap below -2^24
    drive(30'h0000_0030, 18'h00004, 25'h10, 2'b10, 1'b1, "R5");
    drive(30'h0000_0001, 18'h00001, 25'h100_0000, 2'b10, 1'b1, "R5");
    // R6 D alone, A garbage
    drive(30'h3FFF_FFFF, 18'h00007, 25'h0000_0C, 2'b11, 1'b1, "R6");
    drive(30'h1234_5678, 18'h3FFFF, 25'h1AB_CDEF, 2'b11, 1'b1, "R6");
    // R7 signed products at the extremes
    drive(30'h01FF_FFFF, 18'h3FFFF, 25'h0, 2'b00, 1'b1, "R7");
    drive(30'h0100_0000, 18'h20000, 25'h0, 2'b00, 1'b1, "R7");
    drive(30'h00FF_FFFF, 18'h1FFFF, 25'h0, 2'b00, 1'b1, "R7");
    drive(30'h0100_0000, 18'h1FFFF, 25'h0, 2'b00, 1'b1, "R7");
    // R8 concatenation ignores D and the select
    drive(30'h2AAA_5555, 18'h2C3C3, 25'h1FF_FFFF, 2'b01, 1'b0, "R8");
    drive(30'h1357_9BDF, 18'h15A5A, 25'h0AB_CDEF, 2'b11, 1'b0, "R8");
    drive(30'h3FFF_FFFF, 18'h3FFFF, 25'h000_0000, 2'b10, 1'b0, "R8");
    // R9 selects flipping every cycle
    for (int i = 0; i < 200; i++) begin
      drive(30'($urandom), 18'($urandom), 25'($urandom), 2'($urandom),
            1'(i % 2), "R9");
    end
    flush();

    // R10 all enables low: result frozen while inputs churn
    drive(30'h0000_1234, 18'h00567, 25'h0000_089, 2'b01, 1'b1, "R10");
    drive(30'h0000_1234, 18'h00567, 25'h0000_089, 2'b01, 1'b1, "R10");
    drive(30'h0000_1234, 18'h00567, 25'h0000_089, 2'b01, 1'b1, "R10");
    flush();
    @(negedge clk);
    ce_a_i = 2'b00; ce_b_i = 2'b00; ce_d_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      a_i = 30'($urandom); b_i = 18'($urandom); d_i = 25'($urandom);
      mode_i = 2'($urandom); mul_i = 1'($urandom);
      @(posedge clk);
      #2 check("R10", result_o, model(30'h1234, 18'h567, 25'h89, 2'b01, 1'b1));
    end
    @(negedge clk);
    ce_a_i = 2'b11; ce_b_i = 2'b11; ce_d_i = 1'b1;
    drive(30'h0000_0009, 18'h3FFFE, 25'h0000_004, 2'b10, 1'b1, "R10");
    drive(30'h0ABC_0001, 18'h00011, 25'h0000_004, 2'b00, 1'b0, "R10");
    flush();

    // R1 mid-run reset clears the output at once
    drive(30'h0000_0077, 18'h00033, 25'h0, 2'b00, 1'b1, "R1");
    flush();
    @(negedge clk) rst_n = 1'b0;
    #1 check("R1", result_o, 48'h0);
    @(negedge clk) rst_n = 1'b1;
    #1 check("R1", result_o, 48'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule